// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer for a processor subsystem. A free-running counter, 16 bits wide by default, runs from a separate slow time-base clock of roughly 250 kHz rather than from the system clock. A prescaler sits between the time base and the counter, and a small control register selects its divide ratio. When the counter overflows, the block drives a reset pulse back into the system clock domain. Software must keep clearing the counter to prevent that pulse.

Software reaches the block through a byte-wide register bus in the system clock domain. The bus has two addresses: a key register and a control register. After reset the control register is locked and cannot be written. Two consecutive bus writes to the key register unlock it: 0x1E and then 0xE1. The same two bytes in the opposite order lock it again. There is no data stream, so every pin is a plain control or status signal and no valid/ready handshake exists.

Clear requests and the configuration cross from the system domain into the time-base domain. The overflow event crosses back through a two-flop synchronizer. The returned reset is stretched, and it also locks the block and returns it to its defaults.

Top module: `wdog_guard`

## Requirements
- R1: After `rst_n` is released, the control register reads 0x00, the block is locked, and `wdt_rst_o` is low.
- R2: While the block is locked, a write to the control register (address 1) has no effect on its contents.
- R3: A key write (address 0) of 0x1E, followed as the very next bus write by a key write of 0xE1, unlocks the control register. Any bus write in between, including a control write, cancels the sequence.
- R4: A key write of 0xE1, followed as the very next bus write by a key write of 0x1E, locks the control register.
- R5: A key write that is not the expected next byte returns the sequence to its start. The lock state stays as it was.
- R6: Control layout: bit 7 is the enable bit and bits 2:0 are the divide select N. Bit 5 is the clear request and always reads 0. Bits 6, 4 and 3 read 0. A read of the key address returns 0x00.
- R7: The counter advances once every 4^N time-base cycles. It overflows 2^CNT_W × 4^N time-base cycles after counting starts.
- R8: While the enable bit is 0, the counter and prescaler stay at zero and no reset is produced.
- R9: Writing the control register with bit 5 set while unlocked zeroes both the counter and the prescaler.
- R10: An overflow drives `wdt_rst_o` high for exactly RST_CYC (4) consecutive system clock cycles.
- R11: A watchdog reset clears the control register to 0x00 and locks the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tb_clk | input | 1 | Slow time-base clock for the watchdog counter |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 1 | Register select: 0 key, 1 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| wdt_rst_o | output | 1 | Stretched watchdog reset pulse, system domain |

## Verification
The hardest behaviour to reach from the ports is the overflow reset and what follows it. With a 16-bit counter and large divide ratios, an overflow takes far longer than a short run allows. The bench therefore narrows the counter parameter to 6 bits and runs the time base four times slower than the system clock. It then measures the number of system cycles from enable to reset for three divide settings. After each reset it re-checks the lock and the control contents, which shows that the reset path back into the register logic works.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h1E;
  localparam logic [7:0] KEY_SECOND = 8'hE1;
  localparam logic       ADDR_KEY   = 1'b0;
  localparam logic       ADDR_CTL   = 1'b1;
  localparam int         SEL_W      = 3;
  localparam int         EN_POS     = 7;
  localparam int         CLR_POS    = 5;

  typedef enum logic [1:0] {KS_IDLE, KS_HAVE_1E, KS_HAVE_E1} key_st_e;

  typedef struct packed {
    logic             run;
    logic [SEL_W-1:0] sel;
  } wd_cfg_t;
endpackage

// File: rtl/wdog_keylock.sv
module wdog_keylock
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       key_wr,
  input  logic       ctl_wr,
  input  logic [7:0] wdata,
  output logic       unlocked
);
  key_st_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= KS_IDLE;
      unlocked <= 1'b0;
    end else if (soft_rst) begin
      st       <= KS_IDLE;
      unlocked <= 1'b0;
    end else if (key_wr) begin
      case (st)
        KS_IDLE: begin
          if (wdata == KEY_FIRST)       st <= KS_HAVE_1E;
          else if (wdata == KEY_SECOND) st <= KS_HAVE_E1;
          else                          st <= KS_IDLE;
        end
        KS_HAVE_1E: begin
          if (wdata == KEY_SECOND) unlocked <= 1'b1;
          st <= KS_IDLE;
        end
        KS_HAVE_E1: begin
          if (wdata == KEY_FIRST) unlocked <= 1'b0;
          st <= KS_IDLE;
        end
        default: st <= KS_IDLE;
      endcase
    end else if (ctl_wr) begin
      st <= KS_IDLE;
    end
  end

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_wr && !soft_rst) |=> $stable(unlocked)); // R5
  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr && (wdata == KEY_SECOND))); // R3
  AST_SHUT_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(unlocked) && !$past(soft_rst)) |-> $past(key_wr && (wdata == KEY_FIRST))); // R4
endmodule

// File: rtl/wdog_tbcore.sv
module wdog_tbcore
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic    tb_clk,
  input  logic    rst_n,
  input  wd_cfg_t cfg_in,
  input  logic    clr_tgl,
  output logic    ovf_tgl
);
  localparam int PRE_W = 2 * ((1 << SEL_W) - 1);

  logic [1:0]       rs;
  logic             trst_n;
  wd_cfg_t          cfg_m, cfg_s;
  logic [2:0]       clr_sh;
  logic             clr_p;
  logic [PRE_W-1:0] pre, mask;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic [4:0]       shamt;

  always_ff @(posedge tb_clk or negedge rst_n) begin
    if (!rst_n) rs <= 2'b00;
    else        rs <= {rs[0], 1'b1};
  end
  assign trst_n = rs[1];

  always_ff @(posedge tb_clk or negedge trst_n) begin
    if (!trst_n) begin
      cfg_m  <= '0;
      cfg_s  <= '0;
      clr_sh <= '0;
    end else begin
      cfg_m  <= cfg_in;
      cfg_s  <= cfg_m;
      clr_sh <= {clr_sh[1:0], clr_tgl};
    end
  end
  assign clr_p = clr_sh[2] ^ clr_sh[1];

  always_comb begin
    shamt = 5'({cfg_s.sel, 1'b0});
    mask  = ~({PRE_W{1'b1}} << shamt);
    tick  = ((pre & mask) == mask);
  end

  always_ff @(posedge tb_clk or negedge trst_n) begin
    if (!trst_n) begin
      pre     <= '0;
      cnt     <= '0;
      ovf_tgl <= 1'b0;
    end else if (!cfg_s.run || clr_p) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= pre + PRE_W'(1);
      if (tick) begin
        cnt <= cnt + CNT_W'(1);
        if (&cnt) ovf_tgl <= ~ovf_tgl;
      end
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge tb_clk) disable iff (!trst_n)
    !cfg_s.run |=> (cnt == '0 && pre == '0)); // R8
  AST_CLR_ZERO: assert property (@(posedge tb_clk) disable iff (!trst_n)
    clr_p |=> (cnt == '0 && pre == '0)); // R9
  AST_CNT_STEP: assert property (@(posedge tb_clk) disable iff (!trst_n)
    (cfg_s.run && !clr_p && !tick) |=> $stable(cnt)); // R7
endmodule

// File: rtl/wdog_rststretch.sv
module wdog_rststretch #(
  parameter int RST_CYC = 4
)(
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_tgl,
  output logic rst_o
);
  localparam int CW = $clog2(RST_CYC + 1);

  logic [2:0]    sy;
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy   <= '0;
      left <= '0;
    end else begin
      sy <= {sy[1:0], ovf_tgl};
      if (sy[2] ^ sy[1])   left <= CW'(RST_CYC);
      else if (left != '0) left <= left - CW'(1);
    end
  end
  assign rst_o = (left != '0);

  AST_RST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |=> rst_o); // R10
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RST_CYC = 4
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tb_clk,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wdt_rst_o
);
  logic    key_wr, ctl_wr, unlocked, clr_tgl, ovf_tgl, wr_ok;
  wd_cfg_t cfg;

  assign key_wr = bus_wr && (bus_addr == ADDR_KEY);
  assign ctl_wr = bus_wr && (bus_addr == ADDR_CTL);
  assign wr_ok  = ctl_wr && unlocked && !wdt_rst_o;

  wdog_keylock i_keylock (
    .clk(clk), .rst_n(rst_n), .soft_rst(wdt_rst_o), .key_wr(key_wr),
    .ctl_wr(ctl_wr), .wdata(bus_wdata), .unlocked(unlocked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      clr_tgl <= 1'b0;
    end else begin
      if (wdt_rst_o) cfg <= '0;
      else if (wr_ok) begin
        cfg.run <= bus_wdata[EN_POS];
        cfg.sel <= bus_wdata[SEL_W-1:0];
      end
      if (wr_ok && bus_wdata[CLR_POS]) clr_tgl <= ~clr_tgl;
    end
  end

  assign bus_rdata = (bus_addr == ADDR_CTL) ? {cfg.run, 4'b0000, cfg.sel} : 8'h00;

  wdog_tbcore #(.CNT_W(CNT_W)) i_tbcore (
    .tb_clk(tb_clk), .rst_n(rst_n), .cfg_in(cfg), .clr_tgl(clr_tgl), .ovf_tgl(ovf_tgl)
  );

  wdog_rststretch #(.RST_CYC(RST_CYC)) i_stretch (
    .clk(clk), .rst_n(rst_n), .ovf_tgl(ovf_tgl), .rst_o(wdt_rst_o)
  );

  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !wdt_rst_o) |=> $stable(cfg)); // R2
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_CTL) |-> (bus_rdata[6:3] == 4'b0000)); // R6
  AST_WDT_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |=> (cfg == '0 && !unlocked)); // R11
endmodule

// File: tb/test_wdog_guard.sv
module test_wdog_guard;
  logic       clk = 1'b0, tb_clk = 1'b0, rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       wdt_rst_o;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5  clk    = ~clk;
  always #20 tb_clk = ~tb_clk;

  wdog_guard #(.CNT_W(6), .RST_CYC(4)) i_wdog_guard (
    .clk(clk), .rst_n(rst_n), .tb_clk(tb_clk), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_o(wdt_rst_o)
  );

  // {req[3:0], addr, wdata[7:0], expected control readback[7:0]}
  localparam int NV = 19;
  localparam logic [20:0] VEC [NV] = '{
    {4'd2, 1'b1, 8'h03, 8'h00}, {4'd3, 1'b0, 8'h1E, 8'h00}, {4'd3, 1'b1, 8'h03, 8'h00},
    {4'd3, 1'b0, 8'h1E, 8'h00}, {4'd3, 1'b0, 8'hE1, 8'h00}, {4'd6, 1'b1, 8'h5B, 8'h03},
    {4'd6, 1'b1, 8'h7D, 8'h05}, {4'd5, 1'b0, 8'hE1, 8'h05}, {4'd5, 1'b0, 8'h55, 8'h05},
    {4'd5, 1'b1, 8'h02, 8'h02}, {4'd5, 1'b0, 8'h1E, 8'h02}, {4'd5, 1'b0, 8'h1E, 8'h02},
    {4'd4, 1'b0, 8'hE1, 8'h02}, {4'd4, 1'b0, 8'h1E, 8'h02}, {4'd4, 1'b1, 8'h06, 8'h02},
    {4'd5, 1'b0, 8'h1E, 8'h02}, {4'd5, 1'b0, 8'h1E, 8'h02}, {4'd5, 1'b0, 8'hE1, 8'h02},
    {4'd5, 1'b1, 8'h04, 8'h02}
  };

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic unlock();
    wr(1'b0, 8'h1E);
    wr(1'b0, 8'hE1);
  endtask

  // cycles until the reset rises, then its width in system cycles
  task automatic measure(output int n, output int w);
    n = 0; w = 0;
    while (!wdt_rst_o && n < 40000) begin @(negedge clk); n++; end
    while (wdt_rst_o && w < 100) begin @(negedge clk); w++; end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
  end

  initial begin
    logic [7:0] d;
    int n, w, seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);

    // R1 reset state
    rd(1'b1, d); chk("R1 control after reset", d, 8'h00);
    chk("R1 reset output idle", wdt_rst_o, 0);
    rd(1'b0, d); chk("R6 key address reads zero", d, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][16], VEC[i][15:8]);
      rd(1'b1, d);
      chk($sformatf("%s vector %0d", rname(VEC[i][20:17]), i), d, VEC[i][7:0]);
    end

    // R8 disabled watchdog never fires
    unlock(); wr(1'b1, 8'h00);
    seen = 0;
    repeat (1200) begin @(negedge clk); if (wdt_rst_o) seen = 1; end
    chk("R8 disabled no reset", seen, 0);

    // R7/R10/R11 overflow timing for three divide settings
    for (int k = 0; k < 3; k++) begin
      int expc;
      expc = 256 << (2 * k);
      unlock();
      wr(1'b1, 8'h80 | 8'(k));
      measure(n, w);
      chk($sformatf("R7 timeout sel=%0d in window", k),
          (n >= expc - 8 && n <= expc + 48) ? 1 : 0, 1);
      chk("R10 reset width", w, 4);
      rd(1'b1, d); chk("R11 control cleared", d, 8'h00);
      wr(1'b1, 8'h87); rd(1'b1, d); chk("R11 relocked", d, 8'h00);
      repeat (20) @(negedge clk);
    end

    // R9 periodic clears hold off the reset
    unlock(); wr(1'b1, 8'h80);
    seen = 0;
    for (int c = 0; c < 10; c++) begin
      repeat (100) begin @(negedge clk); if (wdt_rst_o) seen = 1; end
      wr(1'b1, 8'hA0);
    end
    chk("R9 no reset while cleared", seen, 0);
    rd(1'b1, d); chk("R6 clear bit reads zero", d, 8'h80);
    measure(n, w);
    chk("R9 timeout restarts after clear", (n >= 248 && n <= 304) ? 1 : 0, 1);
    chk("R10 reset width after clear", w, 4);

    report();
  end
endmodule